// File: doc/BRIEF.md
# Multi-lane transmit ready aggregator

This block tracks buffer-empty status for up to sixteen parallel transmit lanes that move in lockstep. Each lane has a host-writable data buffer that feeds a shift register. The serial shifting itself is not part of this block. Whenever a lane's buffer is copied into its shifter, a transfer strobe for that lane arrives, and the block marks that lane as ready for new data. A host write strobe to that lane's buffer clears the mark again.

The per-lane ready marks of the active lanes combine into one global ready flag. Software can also clear that flag by writing 1 to it. Each cycle in which any active lane transfers is a set event. A set event issues exactly one DMA request pulse, however many lanes took part, and it does so even when the global flag was already high. An interrupt-pending level follows the global flag, gated by its own enable. Both outputs reach the block edge through a fixed five-clock delay.

A small register port gives access to the status and enable bits. Writes are synchronous; reads are combinational.

| Address | Register | Bits |
|---|---|---|
| 0 | Status | bit 5 = global ready flag; writing 1 clears it |
| 1 | Event enable | bit 0 = DMA enable, bit 1 = interrupt enable |
| 16 + n | Lane n control | bit 4 = lane n ready, read-only |

All other bits and addresses read as 0.

Top module: `lane_ready_agg`

## Requirements
- R1: A transfer strobe on a lane whose active-mask bit is 1 sets that lane's ready bit. The bit reads back as bit 4 at register address 16+n, one clock after the strobe.
- R2: A host write strobe to a lane's buffer clears that lane's ready bit, unless a transfer strobe hits the same lane in the same cycle.
- R3: When a transfer strobe and a host write strobe hit the same lane in the same cycle, the set wins and the lane stays ready.
- R4: A lane whose active-mask bit is 0 reads ready as 0. Its transfer strobes set nothing, raise no DMA request and do not set the global flag.
- R5: The global ready flag is read at bit 5 of address 0. It becomes 1 the clock after any active lane transfers. It returns to 0 once no active lane's ready bit remains set.
- R6: Writing a 1 to bit 5 of address 0 clears the global flag, unless a set event happens in the same cycle, in which case the set wins. Writing 0 to that bit has no effect.
- R7: Each cycle with at least one active transfer is a set event. While DMA enable (address 1 bit 0) is 1, a set event produces exactly one single-cycle pulse on dmaReq, five clocks after the strobe edge, however many lanes took part.
- R8: A new set event produces a new DMA pulse even when the global flag is already 1 and no register was read in between.
- R9: irqPend equals the global flag ANDed with interrupt enable (address 1 bit 1), delayed by four clocks. A set event therefore shows on irqPend five clocks after the strobe edge.
- R10: After reset, every ready bit, the global flag, both enables, dmaReq and irqPend are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Active-low synchronous reset |
| laneActive | input | LANES | Active-lane mask |
| xferStb | input | LANES | Per-lane buffer-to-shifter transfer strobe |
| bufWrStb | input | LANES | Per-lane host buffer write strobe |
| regWrEn | input | 1 | Register write enable |
| regWrAddr | input | ADDR_W | Register write address |
| regWrData | input | DATA_W | Register write data |
| regRdAddr | input | ADDR_W | Register read address |
| regRdData | output | DATA_W | Register read data (combinational) |
| dmaReq | output | 1 | DMA request pulse |
| irqPend | output | 1 | Interrupt pending level |

## Verification
The assertions check the following on every cycle:
- An active transfer always leaves its lane ready, and this covers the priority of a set over a clear.
- A write with no transfer clears its lane.
- Inactive lanes stay clear.
- A raised global flag always has some ready lane behind it.
- A write of 1 to the flag clears it when no set event coincides.

Three things only the bench scenarios can show:
- The five-clock timing of the DMA and interrupt outputs.
- Merging of multi-lane transfers into one pulse.
- A repeat pulse while the flag is still high, and the no-effect write of 0.

// File: rtl/lra_pkg.sv
package lra_pkg;
  localparam int ADDR_STATUS    = 0;
  localparam int ADDR_EVCTL     = 1;
  localparam int STAT_GLOBAL_BIT = 5;
  localparam int LANE_RDY_BIT    = 4;
  localparam int EN_DMA_BIT      = 0;
  localparam int EN_IRQ_BIT      = 1;

  typedef struct packed {
    logic setEvt;
    logic clrGlobal;
    logic dmaEn;
    logic irqEn;
  } lraCtrl_t;
endpackage

// File: rtl/lra_delay.sv
module lra_delay #(
  parameter int DEPTH = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] stageQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageQ <= '0;
    end else begin
      stageQ[0] <= d;
      for (int i = 1; i < DEPTH; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  assign q = stageQ[DEPTH-1];
endmodule

// File: rtl/lra_ctrl.sv
module lra_ctrl
  import lra_pkg::*;
#(
  parameter int LANES   = 16,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  parameter int LATENCY = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LANES-1:0]  xferStb,
  input  logic [LANES-1:0]  laneActive,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              globalFlag,
  output lraCtrl_t          ctrl,
  output logic              dmaReq,
  output logic              irqPend
);
  logic dmaEnQ, irqEnQ;
  logic setEvt, clrGlobal, evctlWr;

  assign setEvt    = |(xferStb & laneActive);
  assign clrGlobal = regWrEn && (int'(regWrAddr) == ADDR_STATUS) && regWrData[STAT_GLOBAL_BIT];
  assign evctlWr   = regWrEn && (int'(regWrAddr) == ADDR_EVCTL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaEnQ <= 1'b0;
      irqEnQ <= 1'b0;
    end else if (evctlWr) begin
      dmaEnQ <= regWrData[EN_DMA_BIT];
      irqEnQ <= regWrData[EN_IRQ_BIT];
    end
  end

  always_comb begin
    ctrl.setEvt    = setEvt;
    ctrl.clrGlobal = clrGlobal;
    ctrl.dmaEn     = dmaEnQ;
    ctrl.irqEn     = irqEnQ;
  end

  lra_delay #(.DEPTH(LATENCY)) u_dmaDly (
    .clk(clk), .rstN(rstN), .d(setEvt & dmaEnQ), .q(dmaReq)
  );

  lra_delay #(.DEPTH(LATENCY-1)) u_irqDly (
    .clk(clk), .rstN(rstN), .d(globalFlag & irqEnQ), .q(irqPend)
  );
endmodule

// File: rtl/lra_datapath.sv
module lra_datapath
  import lra_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LANES-1:0]  xferStb,
  input  logic [LANES-1:0]  bufWrStb,
  input  logic [LANES-1:0]  laneActive,
  input  lraCtrl_t          ctrl,
  input  logic [ADDR_W-1:0] regRdAddr,
  output logic [DATA_W-1:0] regRdData,
  output logic [LANES-1:0]  laneRdy,
  output logic              globalFlag
);
  localparam int IDX_W = ADDR_W - 1;

  logic [LANES-1:0] rdyNext;
  logic             anyRdyNext;
  logic [IDX_W-1:0] laneIdx;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      if (!laneActive[g])    rdyNext[g] = 1'b0;
      else if (xferStb[g])   rdyNext[g] = 1'b1;
      else if (bufWrStb[g])  rdyNext[g] = 1'b0;
      else                   rdyNext[g] = laneRdy[g];
    end
    always_ff @(posedge clk) begin
      if (!rstN) laneRdy[g] <= 1'b0;
      else       laneRdy[g] <= rdyNext[g];
    end
  end

  assign anyRdyNext = |rdyNext;

  always_ff @(posedge clk) begin
    if (!rstN)               globalFlag <= 1'b0;
    else if (ctrl.setEvt)    globalFlag <= 1'b1;
    else if (ctrl.clrGlobal) globalFlag <= 1'b0;
    else                     globalFlag <= globalFlag & anyRdyNext;
  end

  assign laneIdx = regRdAddr[IDX_W-1:0];

  always_comb begin
    regRdData = '0;
    if (int'(regRdAddr) == ADDR_STATUS) begin
      regRdData[STAT_GLOBAL_BIT] = globalFlag;
    end else if (int'(regRdAddr) == ADDR_EVCTL) begin
      regRdData[EN_DMA_BIT] = ctrl.dmaEn;
      regRdData[EN_IRQ_BIT] = ctrl.irqEn;
    end else if (regRdAddr[ADDR_W-1] && (int'(laneIdx) < LANES)) begin
      regRdData[LANE_RDY_BIT] = laneRdy[laneIdx];
    end
  end
endmodule

// File: rtl/lane_ready_agg.sv
module lane_ready_agg
  import lra_pkg::*;
#(
  parameter int LANES   = 16,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  parameter int LATENCY = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LANES-1:0]  laneActive,
  input  logic [LANES-1:0]  xferStb,
  input  logic [LANES-1:0]  bufWrStb,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [ADDR_W-1:0] regRdAddr,
  output logic [DATA_W-1:0] regRdData,
  output logic              dmaReq,
  output logic              irqPend
);
  lraCtrl_t         ctrl;
  logic [LANES-1:0] laneRdy;
  logic             globalFlag;

  lra_ctrl #(.LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LATENCY(LATENCY)) u_ctrl (
    .clk(clk), .rstN(rstN), .xferStb(xferStb), .laneActive(laneActive),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .globalFlag(globalFlag), .ctrl(ctrl), .dmaReq(dmaReq), .irqPend(irqPend)
  );

  lra_datapath #(.LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .xferStb(xferStb), .bufWrStb(bufWrStb),
    .laneActive(laneActive), .ctrl(ctrl), .regRdAddr(regRdAddr),
    .regRdData(regRdData), .laneRdy(laneRdy), .globalFlag(globalFlag)
  );
endmodule

// File: rtl/lra_checker.sv
module lra_checker #(
  parameter int LANES  = 16,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [LANES-1:0]  laneActive,
  input logic [LANES-1:0]  xferStb,
  input logic [LANES-1:0]  bufWrStb,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regWrAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [LANES-1:0]  laneRdy,
  input logic              globalFlag
);
  // R1 (with R3 priority)
  set_on_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((xferStb & laneActive) != '0) |=>
      ((laneRdy & $past(xferStb & laneActive)) == $past(xferStb & laneActive)));

  // R2
  clr_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((bufWrStb & ~xferStb) != '0) |=>
      ((laneRdy & $past(bufWrStb & ~xferStb)) == '0));

  // R4
  inactive_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((laneRdy & ~$past(laneActive)) == '0));

  // R5
  global_backed_chk: assert property (@(posedge clk) disable iff (!rstN)
    globalFlag |-> (laneRdy != '0));

  // R6
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (int'(regWrAddr) == 0) && regWrData[5] && ((xferStb & laneActive) == '0))
      |=> !globalFlag);
endmodule

bind lane_ready_agg lra_checker #(.LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .laneActive(laneActive), .xferStb(xferStb),
  .bufWrStb(bufWrStb), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
  .regWrData(regWrData), .laneRdy(laneRdy), .globalFlag(globalFlag)
);

// File: tb/sim_lane_ready_agg.sv
`timescale 1ns/1ps
module sim_lane_ready_agg;
  localparam int L = 16;
  localparam int AW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [L-1:0] laneActive = '0, xferStb = '0, bufWrStb = '0;
  logic regWrEn = 1'b0;
  logic [AW-1:0] regWrAddr = '0, regRdAddr = '0;
  logic [DW-1:0] regWrData = '0;
  logic [DW-1:0] regRdData;
  logic dmaReq, irqPend;

  int checks = 0;
  int failures = 0;

  logic [L-1:0] mRdy;
  logic mGlob, mDmaEn, mIrqEn;
  logic [4:0] mDmaHist;
  logic [3:0] mIrqHist;

  always #4 clk = ~clk;

  lane_ready_agg u0 (
    .clk(clk), .rstN(rstN), .laneActive(laneActive), .xferStb(xferStb),
    .bufWrStb(bufWrStb), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .dmaReq(dmaReq), .irqPend(irqPend)
  );

  task automatic checkEq(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readReg(input int addr, output logic [DW-1:0] data);
    regRdAddr = AW'(addr);
    #0.01;
    data = regRdData;
  endtask

  task automatic readLanes(output logic [L-1:0] v);
    logic [DW-1:0] d;
    for (int i = 0; i < L; i++) begin
      readReg(16 + i, d);
      v[i] = d[4];
    end
  endtask

  function automatic logic [L-1:0] nextRdy(input logic [L-1:0] r, x, w, a);
    return ((r & ~w) | x) & a;
  endfunction

  task automatic modelClock();
    logic setE, w1c;
    logic [L-1:0] nr;
    setE = |(xferStb & laneActive);
    w1c = regWrEn && (regWrAddr == 0) && regWrData[5];
    nr = nextRdy(mRdy, xferStb, bufWrStb, laneActive);
    mDmaHist = {mDmaHist[3:0], setE & mDmaEn};
    mIrqHist = {mIrqHist[2:0], mGlob & mIrqEn};
    if (setE)     mGlob = 1'b1;
    else if (w1c) mGlob = 1'b0;
    else          mGlob = mGlob & (|nr);
    mRdy = nr;
    if (regWrEn && regWrAddr == 1) begin
      mDmaEn = regWrData[0];
      mIrqEn = regWrData[1];
    end
  endtask

  task automatic checkAll();
    logic [DW-1:0] d;
    logic [L-1:0] v;
    checkEq(32'(dmaReq), 32'(mDmaHist[4]), "R7 dmaReq");
    checkEq(32'(irqPend), 32'(mIrqHist[3]), "R9 irqPend");
    readReg(0, d);
    checkEq(d, 32'(mGlob) << 5, "R5 status");
    readReg(1, d);
    checkEq(d, {30'd0, mIrqEn, mDmaEn}, "R7 evctl");
    readLanes(v);
    checkEq(32'(v), 32'(mRdy), "R1 lanes");
  endtask

  task automatic doStep(input logic [L-1:0] x, w, input logic we,
                        input int wa, input logic [DW-1:0] wd);
    xferStb = x; bufWrStb = w; regWrEn = we; regWrAddr = AW'(wa); regWrData = wd;
    @(posedge clk);
    modelClock();
    @(negedge clk);
    xferStb = '0; bufWrStb = '0; regWrEn = 1'b0; regWrData = '0;
    checkAll();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) doStep('0, '0, 1'b0, 0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic [L-1:0] v;
    void'($urandom(32'h5eed_1234));
    mRdy = '0; mGlob = 0; mDmaEn = 0; mIrqEn = 0; mDmaHist = '0; mIrqHist = '0;
    laneActive = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    checkEq(32'(dmaReq), 0, "R10 dmaReq");
    checkEq(32'(irqPend), 0, "R10 irqPend");
    readReg(0, d); checkEq(d, 0, "R10 status");
    readReg(1, d); checkEq(d, 0, "R10 evctl");
    readLanes(v); checkEq(32'(v), 0, "R10 lanes");

    // enable both events
    doStep('0, '0, 1'b1, 1, 32'h3);

    // R7: multi-lane transfer gives one pulse five clocks later
    doStep(16'hF0F0, '0, 1'b0, 0, '0);
    idle(3);
    checkEq(32'(dmaReq), 0, "R7 not early");
    idle(1);
    checkEq(32'(dmaReq), 1, "R7 pulse");
    checkEq(32'(irqPend), 1, "R9 irq after latency");
    idle(1);
    checkEq(32'(dmaReq), 0, "R7 single pulse");

    // R8: new set while global flag still high
    readReg(0, d); checkEq(32'(d[5]), 1, "R8 flag still set");
    doStep(16'h0001, '0, 1'b0, 0, '0);
    idle(4);
    checkEq(32'(dmaReq), 1, "R8 repeat pulse");

    // R2: writes clear lanes; R5 flag drops once all written
    doStep('0, 16'hF0F1, 1'b0, 0, '0);
    readLanes(v); checkEq(32'(v), 0, "R2 cleared");
    readReg(0, d); checkEq(32'(d[5]), 0, "R5 flag dropped");

    // R3: same-cycle set and write
    doStep(16'h0008, 16'h0008, 1'b0, 0, '0);
    readReg(16 + 3, d); checkEq(32'(d[4]), 1, "R3 set wins");

    // R6: write 0 no effect, write 1 clears
    doStep('0, '0, 1'b1, 0, 32'hFFFF_FFDF);
    readReg(0, d); checkEq(32'(d[5]), 1, "R6 write0 no effect");
    doStep('0, '0, 1'b1, 0, 32'h20);
    readReg(0, d); checkEq(32'(d[5]), 0, "R6 w1c");
    readReg(16 + 3, d); checkEq(32'(d[4]), 1, "R6 lane kept");
    doStep(16'h0010, '0, 1'b1, 0, 32'h20);
    readReg(0, d); checkEq(32'(d[5]), 1, "R6 set beats w1c");
    idle(5);

    // R4: inactive lane
    laneActive = 16'hFF7F;
    doStep('0, '1, 1'b0, 0, '0);
    doStep(16'h0080, '0, 1'b0, 0, '0);
    readReg(16 + 7, d); checkEq(32'(d[4]), 0, "R4 inactive lane");
    readReg(0, d); checkEq(32'(d[5]), 0, "R4 no global");
    idle(4);
    checkEq(32'(dmaReq), 0, "R4 no dma");

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [L-1:0] x, w;
      logic we;
      int wa;
      logic [DW-1:0] wd;
      if (($urandom % 16) == 0) laneActive = L'($urandom);
      x = L'($urandom & $urandom & $urandom);
      if (($urandom % 3) != 0) x = '0;
      w = L'($urandom & $urandom);
      we = (($urandom % 8) == 0);
      wa = $urandom % 2;
      wd = $urandom;
      doStep(x, w, we, wa, wd);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule